// File: doc/BRIEF.md
# Sensor Register Burst Read Sequencer

This block produces the register address for every byte of a multi-byte host read from a motion sensor's register file. The host loads a start address. Each byte-read strobe then moves the address one step forward. While it steps through the output data registers, the sequencer keeps the read inside a window that depends on which sensors are enabled. At the end of that window it jumps back to the window's first register, so the host can read a stream of samples without sending a new address.

The output data is laid out as two blocks of three axes, ordered X, Y, Z. Each axis takes a low byte and then a high byte. The rotation block covers 18h to 1Dh and the acceleration block covers 28h to 2Dh.

- With only acceleration enabled, the window is 28h to 2Dh.
- With both sensors enabled, the window runs from 18h to 2Dh. It jumps straight from 1Dh to 28h, over the unused gap.
- With only rotation enabled, the window is 18h to 1Dh.
- With neither sensor enabled, the address simply counts up.

A start address outside the window counts up linearly until it enters the window.

The sequencer raises a wrap flag for one cycle whenever it returns to the restart point. The serial bus protocol, the register storage and the sensor data path are outside this block.

Top module: `sensor_burst_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, addr_o becomes 00h and wrap_o becomes 0.
- R2: With accel_en_i=1 and gyro_en_i=0, each strobe steps addr_o by one through 28h..2Dh, and a strobe at 2Dh sets addr_o to 28h.
- R3: With both enables high, each strobe steps addr_o by one inside 18h..1Ch and inside 28h..2Ch.
- R4: With both enables high, a strobe at 1Dh sets addr_o to 28h, skipping 1Eh..27h.
- R5: With both enables high, a strobe at 2Dh sets addr_o to 18h.
- R6: A cycle with start_i=1 loads start_addr_i into addr_o on the next edge, and this takes priority over rd_strobe_i.
- R7: A cycle with start_i=0 and rd_strobe_i=0 leaves addr_o unchanged.
- R8: wrap_o is 1 for exactly the cycle after a strobe that returns addr_o to the restart point (R2, R5, R11), and 0 otherwise, including after the R4 gap jump.
- R9: With both enables low, each strobe adds one to addr_o, modulo 256 (FFh goes to 00h), and wrap_o stays 0.
- R10: In any mode, a strobe at an address that is neither a window end nor the gap end adds one to addr_o, modulo 256. A start outside the window therefore counts up until it enters the window.
- R11: With gyro_en_i=1 and accel_en_i=0, each strobe steps addr_o by one through 18h..1Dh, and a strobe at 1Dh sets addr_o to 18h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load start_addr_i as the burst start |
| start_addr_i | input | 8 | Start register address from the host |
| rd_strobe_i | input | 1 | One byte has been read; advance the address |
| accel_en_i | input | 1 | Acceleration sensor enabled |
| gyro_en_i | input | 1 | Rotation sensor enabled |
| addr_o | output | 8 | Current register address |
| wrap_o | output | 1 | One-cycle pulse on return to the restart point |

## Verification
On every cycle, the assertions check the following:
- the load and its priority over a strobe;
- holding the address when the block is idle;
- the linear step when both sensors are off;
- the jumps at the window ends and at the gap;
- that the wrap flag never lasts two cycles.

Some behaviour only the bench's sweep can show. It runs every start address in all four enable settings for a full window length of strobes. This shows that addresses outside the window count up and enter it at the right point. It also shows that the 8-bit count rolls over, and that the wrap flag is low for every step that is not a wrap, including the gap jump.

// File: rtl/sbs_pkg.sv
// Package: shared types for the burst read sequencer.
// Assumes: the two enable flags are mapped onto one of four modes.
package sbs_pkg;
    typedef enum logic [1:0] {
        MODE_LINEAR = 2'd0,
        MODE_ACCEL  = 2'd1,
        MODE_GYRO   = 2'd2,
        MODE_BOTH   = 2'd3
    } burst_mode_e;
endpackage

// File: rtl/sbs_mode_decode.sv
// Module: turns the sensor enable flags into a window mode.
// Assumes: the enables are steady while a burst is in progress; a change
// takes effect on the next strobe.
module sbs_mode_decode
    import sbs_pkg::*;
(
    input  logic        accel_en,
    input  logic        gyro_en,
    output burst_mode_e mode
);
    // Pick the window from the enable combination.
    always_comb begin
        case ({gyro_en, accel_en})
            2'b01:   mode = MODE_ACCEL;
            2'b10:   mode = MODE_GYRO;
            2'b11:   mode = MODE_BOTH;
            default: mode = MODE_LINEAR;
        endcase
    end
endmodule

// File: rtl/sbs_next_addr.sv
// Module: computes the address that follows the current one for a mode.
// It also flags the steps that return to the restart point.
// Assumes: the rotation block sits below the acceleration block, and each
// block holds AXES axes of BYTES_PER_AXIS bytes.
module sbs_next_addr
    import sbs_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int GYRO_BASE      = 'h18,
    parameter int ACCEL_BASE     = 'h28,
    parameter int AXES           = 3,
    parameter int BYTES_PER_AXIS = 2
) (
    input  burst_mode_e       mode,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              wraps
);
    localparam int BLOCK_LEN = AXES * BYTES_PER_AXIS;
    localparam logic [ADDR_W-1:0] GYR_FIRST = ADDR_W'(GYRO_BASE);
    localparam logic [ADDR_W-1:0] GYR_LAST  = ADDR_W'(GYRO_BASE + BLOCK_LEN - 1);
    localparam logic [ADDR_W-1:0] ACC_FIRST = ADDR_W'(ACCEL_BASE);
    localparam logic [ADDR_W-1:0] ACC_LAST  = ADDR_W'(ACCEL_BASE + BLOCK_LEN - 1);

    logic [ADDR_W-1:0] incremented;

    // Default step is a plain increment; window ends and the gap override it.
    always_comb begin
        incremented = cur_addr + ADDR_W'(1);
        next_addr   = incremented;
        wraps       = 1'b0;
        case (mode)
            MODE_BOTH: begin
                if (cur_addr == ACC_LAST) begin
                    next_addr = GYR_FIRST;
                    wraps     = 1'b1;
                end else if (cur_addr == GYR_LAST) begin
                    next_addr = ACC_FIRST;
                end
            end
            MODE_ACCEL: begin
                if (cur_addr == ACC_LAST) begin
                    next_addr = ACC_FIRST;
                    wraps     = 1'b1;
                end
            end
            MODE_GYRO: begin
                if (cur_addr == GYR_LAST) begin
                    next_addr = GYR_FIRST;
                    wraps     = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sbs_addr_reg.sv
// Module: holds the current address and the wrap pulse.
// Assumes: load has priority over advance; with neither, the address holds.
module sbs_addr_reg #(
    parameter int ADDR_W     = 8,
    parameter int RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              wraps,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    // Address register: reset, then load, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= ADDR_W'(RESET_ADDR);
        end else if (load) begin
            addr <= load_addr;
        end else if (advance) begin
            addr <= next_addr;
        end
    end

    // Wrap pulse: high for one cycle after an advance that wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap <= 1'b0;
        end else begin
            wrap <= !load && advance && wraps;
        end
    end
endmodule

// File: rtl/sensor_burst_sequencer.sv
// Module: top of the burst read address sequencer.
// Assumes: one strobe per byte read; the host pulses start_i once per burst.
module sensor_burst_sequencer
    import sbs_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int GYRO_BASE      = 'h18,
    parameter int ACCEL_BASE     = 'h28,
    parameter int AXES           = 3,
    parameter int BYTES_PER_AXIS = 2,
    parameter int RESET_ADDR     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              rd_strobe_i,
    input  logic              accel_en_i,
    input  logic              gyro_en_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);
    localparam int BLOCK_LEN = AXES * BYTES_PER_AXIS;
    localparam logic [ADDR_W-1:0] GYR_FIRST = ADDR_W'(GYRO_BASE);
    localparam logic [ADDR_W-1:0] GYR_LAST  = ADDR_W'(GYRO_BASE + BLOCK_LEN - 1);
    localparam logic [ADDR_W-1:0] ACC_FIRST = ADDR_W'(ACCEL_BASE);
    localparam logic [ADDR_W-1:0] ACC_LAST  = ADDR_W'(ACCEL_BASE + BLOCK_LEN - 1);

    burst_mode_e       mode;
    logic [ADDR_W-1:0] next_addr;
    logic              wraps;

    sbs_mode_decode u_decode (
        .accel_en (accel_en_i),
        .gyro_en  (gyro_en_i),
        .mode     (mode)
    );

    sbs_next_addr #(
        .ADDR_W         (ADDR_W),
        .GYRO_BASE      (GYRO_BASE),
        .ACCEL_BASE     (ACCEL_BASE),
        .AXES           (AXES),
        .BYTES_PER_AXIS (BYTES_PER_AXIS)
    ) u_next (
        .mode      (mode),
        .cur_addr  (addr_o),
        .next_addr (next_addr),
        .wraps     (wraps)
    );

    sbs_addr_reg #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_i),
        .load_addr (start_addr_i),
        .advance   (rd_strobe_i),
        .next_addr (next_addr),
        .wraps     (wraps),
        .addr      (addr_o),
        .wrap      (wrap_o)
    );

    AST_ACC_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && rd_strobe_i && accel_en_i && !gyro_en_i && addr_o == ACC_LAST)
        |=> (addr_o == ACC_FIRST && wrap_o)); // R2
    AST_GAP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && rd_strobe_i && accel_en_i && gyro_en_i && addr_o == GYR_LAST)
        |=> (addr_o == ACC_FIRST && !wrap_o)); // R4
    AST_BOTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && rd_strobe_i && accel_en_i && gyro_en_i && addr_o == ACC_LAST)
        |=> (addr_o == GYR_FIRST && wrap_o)); // R5
    AST_GYRO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && rd_strobe_i && !accel_en_i && gyro_en_i && addr_o == GYR_LAST)
        |=> (addr_o == GYR_FIRST && wrap_o)); // R11
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(start_addr_i) && !wrap_o)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !rd_strobe_i) |=> ($stable(addr_o) && !wrap_o)); // R7
    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o); // R8
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && rd_strobe_i && !accel_en_i && !gyro_en_i)
        |=> (addr_o == $past(addr_o) + ADDR_W'(1) && !wrap_o)); // R9
endmodule

// File: tb/sensor_burst_sequencer_bench.sv
module sensor_burst_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_addr_i = 8'h00;
    logic       rd_strobe_i = 1'b0;
    logic       accel_en_i = 1'b0;
    logic       gyro_en_i = 1'b0;
    logic [7:0] addr_o;
    logic       wrap_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sensor_burst_sequencer u_sensor_burst_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .rd_strobe_i  (rd_strobe_i),
        .accel_en_i   (accel_en_i),
        .gyro_en_i    (gyro_en_i),
        .addr_o       (addr_o),
        .wrap_o       (wrap_o)
    );

    task automatic check(input string req, input logic [7:0] exp_a, input logic exp_w);
        compared++;
        if (addr_o !== exp_a || wrap_o !== exp_w) begin
            mismatched++;
            $display("FAIL %s: addr=%h wrap=%b expected addr=%h wrap=%b",
                     req, addr_o, wrap_o, exp_a, exp_w);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, then sample after the rising edge.
    task automatic cycle(input logic st, input logic [7:0] sa, input logic rd);
        @(negedge clk);
        start_i = st;
        start_addr_i = sa;
        rd_strobe_i = rd;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] a, input logic acc, input logic gyr);
        logic [7:0] n;
        n = a + 8'd1;
        if (acc && a == 8'h2D) n = gyr ? 8'h18 : 8'h28;
        else if (gyr && a == 8'h1D) n = acc ? 8'h28 : 8'h18;
        return n;
    endfunction

    function automatic logic model_wrap(input logic [7:0] a, input logic acc, input logic gyr);
        return (acc && a == 8'h2D) || (gyr && !acc && a == 8'h1D);
    endfunction

    function automatic string tag_for(input logic [7:0] a, input logic acc, input logic gyr);
        bit in_g, in_a;
        in_g = (a >= 8'h18 && a <= 8'h1D);
        in_a = (a >= 8'h28 && a <= 8'h2D);
        if (!acc && !gyr) return "R9";
        if (acc && gyr) begin
            if (a == 8'h2D) return "R5";
            if (a == 8'h1D) return "R4";
            if (in_g || in_a) return "R3";
            return "R10";
        end
        if (acc) return in_a ? "R2" : "R10";
        return in_g ? "R11" : "R10";
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_a;
        logic       exp_w;
        // R1 reset state, with a strobe and a start pending during reset
        start_i = 1'b1;
        start_addr_i = 8'h55;
        rd_strobe_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        start_i = 1'b0;
        rd_strobe_i = 1'b0;

        // R7 hold while idle
        accel_en_i = 1'b1;
        cycle(1'b1, 8'h2A, 1'b0);
        check("R6", 8'h2A, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 8'h00, 1'b0);
            check("R7", 8'h2A, 1'b0);
        end
        // R6 start wins over a strobe given in the same cycle, even at a window end
        cycle(1'b1, 8'h2D, 1'b0);
        cycle(1'b1, 8'h70, 1'b1);
        check("R6", 8'h70, 1'b0);

        // Sweep every mode and every start address
        for (int m = 0; m < 4; m++) begin
            accel_en_i = m[0];
            gyro_en_i  = m[1];
            for (int s = 0; s < 256; s++) begin
                cycle(1'b1, 8'(s), 1'b0);
                check("R6", 8'(s), 1'b0);
                exp_a = 8'(s);
                for (int k = 0; k < 14; k++) begin
                    string t;
                    t = tag_for(exp_a, accel_en_i, gyro_en_i);
                    exp_w = model_wrap(exp_a, accel_en_i, gyro_en_i);
                    exp_a = model_next(exp_a, accel_en_i, gyro_en_i);
                    cycle(1'b0, 8'h00, 1'b1);
                    check(exp_w ? "R8" : t, exp_a, exp_w);
                end
                // wrap pulse must drop after one cycle when idle
                cycle(1'b0, 8'h00, 1'b0);
                check("R8", exp_a, 1'b0);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule